// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo serial audio stream into parallel sample pairs. The three wires are a bit clock, a left/right word clock and a data line. The block runs directly on the incoming bit clock. On each rising edge it samples the data line and the word clock.

A three-bit format code selects the framing:

- right-justified words of 16, 20 or 24 bits;
- left-justified 24-bit words;
- I2S-style words of 16 or 24 bits.

A separate control inverts which word-clock level marks the left channel.

Each channel word is sign-extended to a 24-bit two's complement value. The left word of a frame is held until the right word of the same frame completes. Both are then presented together with a single-cycle valid pulse. Moving the samples into a system clock domain is left to the consumer.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is low at a rising bit-clock edge, and after that edge, `sample_valid` is 0 and both sample outputs are 0.
- R2: The data and word-clock lines are sampled on the rising bit-clock edge, most significant bit first. Bit-clock rates of 32, 48 and 64 times the word-clock rate are supported, within the limits of R3 to R5.
- R3: Format codes 000, 001 and 010 select right-justified words of 16, 20 and 24 bits. The least significant bit is on the last bit clock before the word-clock transition that ends the channel's phase.
- R4: Format code 011 selects 24-bit left-justified words. The most significant bit is on the first bit clock after the word-clock transition.
- R5: Format codes 100 and 101 select I2S-style words of 16 and 24 bits. The most significant bit is on the second bit clock after the word-clock transition.
- R6: With the swap control at 0, the left channel is on the word-clock high phase for codes 0xx, and on the low phase for codes 10x.
- R7: With the swap control at 1, the word-clock level that denotes the left channel is inverted with respect to R6.
- R8: Each output word is the received word sign-extended to 24 bits.
- R9: `sample_valid` is high for exactly one bit-clock cycle per frame. It rises one cycle after the right word completes, and the left output then carries the left word received just before it. Both outputs hold their value between pulses.
- R10: Format codes 110 and 111 produce no valid pulse and leave the outputs unchanged.
- R11: No word is taken from the channel phase in progress when reset is released. As a result, the first frame after reset yields no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck | input | 1 | Word clock that selects the channel |
| sdata | input | 1 | Serial data line |
| fmt | input | 3 | Format code; see R3, R4, R5 and R10 |
| lr_swap | input | 1 | Inverts the word-clock level that denotes left |
| left_out | output | 24 | Sign-extended left sample |
| right_out | output | 24 | Sign-extended right sample |
| sample_valid | output | 1 | One-cycle pulse marking a new sample pair |

## Verification
The bench builds the block with its default parameters: a 24-bit output and a 5-bit saturating bit counter. The counter reaches past the longest I2S offset of 25 bits, so every legal word position within a 64-bit frame is reachable.

Each format is driven at a bit-clock ratio it fits:

- 16-bit right-justified at 32, where the word fills the whole phase;
- 20-bit right-justified at 48;
- 24-bit left-justified at 48, where the word fills the whole phase;
- 16-bit I2S at 48, with I2S 24-bit at 64.

Unused bit slots are driven high, so that a shift or offset error alters the sign-extended result. Both swap settings are tried for the right-justified, left-justified and I2S framings. Both reserved codes are also run.

// File: rtl/sarx_pkg.sv
// Shared types and helpers for the serial audio receiver.
// Assumes a 24-bit output word; shorter words are sign-extended to it.
package sarx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 2);

    typedef enum logic [1:0] {
        JUST_RIGHT = 2'd0,
        JUST_LEFT  = 2'd1,
        JUST_I2S   = 2'd2
    } just_e;

    typedef enum logic [1:0] {
        LEN16 = 2'd0,
        LEN20 = 2'd1,
        LEN24 = 2'd2
    } len_e;

    typedef struct packed {
        logic  reserved;   // code carries no defined framing
        just_e just;       // word placement inside a phase
        len_e  len;        // word length
        logic  left_lvl;   // word-clock level that means left
    } cfg_t;

    // Sign-extend the low bits of raw according to the word length.
    function automatic logic [SAMPLE_W-1:0] sext(input logic [SAMPLE_W-1:0] raw,
                                                 input len_e len);
        case (len)
            LEN16:   return {{(SAMPLE_W-16){raw[15]}}, raw[15:0]};
            LEN20:   return {{(SAMPLE_W-20){raw[19]}}, raw[19:0]};
            default: return raw;
        endcase
    endfunction

endpackage

// File: rtl/sarx_fmt_decode.sv
// Format decoder: maps the three-bit format code and the swap control
// to the framing, the word length and the word-clock level of the left
// channel. Purely combinational; assumes the controls are held steady
// while a stream is running.
module sarx_fmt_decode
    import sarx_pkg::*;
(
    input  logic [2:0] fmt,
    input  logic       lr_swap,
    output cfg_t       cfg
);

    // Decode framing and length; default left level is high, low for I2S.
    always_comb begin
        cfg.reserved = 1'b0;
        cfg.just     = JUST_RIGHT;
        cfg.len      = LEN16;
        cfg.left_lvl = fmt[2] ? lr_swap : ~lr_swap;
        case (fmt)
            3'b000: begin cfg.just = JUST_RIGHT; cfg.len = LEN16; end
            3'b001: begin cfg.just = JUST_RIGHT; cfg.len = LEN20; end
            3'b010: begin cfg.just = JUST_RIGHT; cfg.len = LEN24; end
            3'b011: begin cfg.just = JUST_LEFT;  cfg.len = LEN24; end
            3'b100: begin cfg.just = JUST_I2S;   cfg.len = LEN16; end
            3'b101: begin cfg.just = JUST_I2S;   cfg.len = LEN24; end
            default: cfg.reserved = 1'b1;
        endcase
    end

endmodule

// File: rtl/sarx_edge_track.sv
// Word-clock tracker: remembers the previous word-clock sample, flags
// the bit-clock edge on which a new channel phase begins, and counts
// bit clocks since that edge (saturating). The first sample after reset
// only primes the history, so no false transition is reported.
// Assumes each channel phase lasts at least two bit clocks.
module sarx_edge_track #(
    parameter int CNT_W = 5
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             lrck,
    output logic             phase_start,
    output logic             prev_lvl,
    output logic             synced_before,
    output logic             synced_now,
    output logic [CNT_W-1:0] bit_idx
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             primed_q;
    logic             prev_q;
    logic             synced_q;
    logic [CNT_W-1:0] cnt_q;

    // A phase starts when the sampled level differs from the last one.
    always_comb begin
        phase_start   = primed_q & (lrck ^ prev_q);
        bit_idx       = phase_start ? '0 : cnt_q;
        prev_lvl      = prev_q;
        synced_before = synced_q;
        synced_now    = synced_q | phase_start;
    end

    // Keep word-clock history, sync state and the saturating bit count.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            primed_q <= 1'b0;
            prev_q   <= 1'b0;
            synced_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            primed_q <= 1'b1;
            prev_q   <= lrck;
            synced_q <= synced_q | phase_start;
            cnt_q    <= (bit_idx == CNT_MAX) ? bit_idx : bit_idx + CNT_W'(1);
        end
    end

    AST_NO_FAST_TOGGLE: assert property (@(posedge bclk) disable iff (!rst_n)
        phase_start |=> !phase_start); // R2

endmodule

// File: rtl/sarx_word_capture.sv
// Word capture: shifts every data bit into a register and decides when
// a complete channel word is present.
// - Right-justified words are taken from the bits already shifted in,
//   on the edge that starts the next phase, so the bit-clock ratio need
//   not be known.
// - Left-justified and I2S words are taken when the bit count since the
//   phase start reaches the word's last bit.
// Assumes the phase is long enough to hold the selected word.
module sarx_word_capture
    import sarx_pkg::*;
#(
    parameter int W     = SAMPLE_W,
    parameter int CNT_W = 5
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             sdata,
    input  logic             lrck,
    input  cfg_t             cfg,
    input  logic             phase_start,
    input  logic             prev_lvl,
    input  logic             synced_before,
    input  logic             synced_now,
    input  logic [CNT_W-1:0] bit_idx,
    output logic             word_done,
    output logic             word_is_left,
    output logic [W-1:0]     word
);

    logic [W-1:0]     sh_q;
    logic [W-1:0]     sh_nxt;
    logic [CNT_W-1:0] last_idx;
    logic             rj_fire;
    logic             ph_fire;

    // Index of the word's final bit within a phase for the leading framings.
    always_comb begin
        case (cfg.len)
            LEN16:   last_idx = CNT_W'(15);
            LEN20:   last_idx = CNT_W'(19);
            default: last_idx = CNT_W'(23);
        endcase
        if (cfg.just == JUST_I2S) last_idx = last_idx + CNT_W'(1);
    end

    // Decide whether a word completes on this edge and which channel it is.
    always_comb begin
        sh_nxt  = {sh_q[W-2:0], sdata};
        rj_fire = !cfg.reserved && (cfg.just == JUST_RIGHT) && phase_start && synced_before;
        ph_fire = !cfg.reserved && (cfg.just != JUST_RIGHT) && synced_now && (bit_idx == last_idx);
        word_done    = rj_fire | ph_fire;
        word_is_left = rj_fire ? (prev_lvl == cfg.left_lvl) : (lrck == cfg.left_lvl);
        word         = sext(rj_fire ? sh_q : sh_nxt, cfg.len);
    end

    // Shift every sampled data bit in, most significant first.
    always_ff @(posedge bclk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_nxt;
    end

    AST_WORD_NEEDS_SYNC: assert property (@(posedge bclk) disable iff (!rst_n)
        word_done |-> $past(rst_n) && synced_now); // R11

endmodule

// File: rtl/sarx_pair_out.sv
// Pair assembler: keeps the most recent left word and, when a right word
// completes, moves both to the outputs together with a one-cycle valid.
// A right word with no left word before it is dropped.
module sarx_pair_out #(
    parameter int W = 24
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         word_done,
    input  logic         word_is_left,
    input  logic [W-1:0] word,
    output logic [W-1:0] left_out,
    output logic [W-1:0] right_out,
    output logic         sample_valid
);

    logic [W-1:0] hold_q;
    logic         have_q;
    logic [W-1:0] left_q;
    logic [W-1:0] right_q;
    logic         valid_q;

    // Hold the left word, then publish the pair on the right word.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            have_q  <= 1'b0;
            left_q  <= '0;
            right_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (word_done && word_is_left) begin
                hold_q <= word;
                have_q <= 1'b1;
            end else if (word_done && have_q) begin
                left_q  <= hold_q;
                right_q <= word;
                valid_q <= 1'b1;
                have_q  <= 1'b0;
            end
        end
    end

    assign left_out     = left_q;
    assign right_out    = right_q;
    assign sample_valid = valid_q;

    AST_VALID_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R9

    AST_HOLD_OUTPUTS: assert property (@(posedge bclk) disable iff (!rst_n)
        !valid_q |-> ($stable(left_q) && $stable(right_q))); // R9

    AST_RIGHT_CLOSES_PAIR: assert property (@(posedge bclk) disable iff (!rst_n)
        valid_q |-> $past(word_done && !word_is_left)); // R9

endmodule

// File: rtl/serial_audio_rx.sv
// Multi-format serial audio receiver, top level. Runs on the incoming
// bit clock; the format code and swap control are assumed steady while
// a stream is received. Outputs stay in the bit-clock domain.
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int W      = SAMPLE_W,
    parameter int CNT_WD = CNT_W
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         lrck,
    input  logic         sdata,
    input  logic [2:0]   fmt,
    input  logic         lr_swap,
    output logic [W-1:0] left_out,
    output logic [W-1:0] right_out,
    output logic         sample_valid
);

    cfg_t              cfg;
    logic              phase_start;
    logic              prev_lvl;
    logic              synced_before;
    logic              synced_now;
    logic [CNT_WD-1:0] bit_idx;
    logic              word_done;
    logic              word_is_left;
    logic [W-1:0]      word;

    sarx_fmt_decode u_dec (
        .fmt     (fmt),
        .lr_swap (lr_swap),
        .cfg     (cfg)
    );

    sarx_edge_track #(.CNT_W(CNT_WD)) u_edge (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .lrck          (lrck),
        .phase_start   (phase_start),
        .prev_lvl      (prev_lvl),
        .synced_before (synced_before),
        .synced_now    (synced_now),
        .bit_idx       (bit_idx)
    );

    sarx_word_capture #(.W(W), .CNT_W(CNT_WD)) u_cap (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .sdata         (sdata),
        .lrck          (lrck),
        .cfg           (cfg),
        .phase_start   (phase_start),
        .prev_lvl      (prev_lvl),
        .synced_before (synced_before),
        .synced_now    (synced_now),
        .bit_idx       (bit_idx),
        .word_done     (word_done),
        .word_is_left  (word_is_left),
        .word          (word)
    );

    sarx_pair_out #(.W(W)) u_pair (
        .bclk         (bclk),
        .rst_n        (rst_n),
        .word_done    (word_done),
        .word_is_left (word_is_left),
        .word         (word),
        .left_out     (left_out),
        .right_out    (right_out),
        .sample_valid (sample_valid)
    );

    AST_RESERVED_SILENT: assert property (@(posedge bclk) disable iff (!rst_n)
        (fmt[2:1] == 2'b11 && $past(fmt[2:1] == 2'b11)) |-> !sample_valid); // R10

endmodule

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrck = 1'b0;
    logic        sdata = 1'b0;
    logic [2:0]  fmt = 3'b000;
    logic        lr_swap = 1'b0;
    logic [23:0] left_out;
    logic [23:0] right_out;
    logic        sample_valid;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    int wide_cnt = 0;
    logic        prev_v = 1'b0;
    logic [23:0] pl = '0, pr = '0, ll = '0, lr = '0;

    always #5 bclk = ~bclk;

    serial_audio_rx u0 (
        .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata),
        .fmt(fmt), .lr_swap(lr_swap),
        .left_out(left_out), .right_out(right_out), .sample_valid(sample_valid)
    );

    // Monitor away from the active edge: record the last two pairs and pulse widths.
    always @(negedge bclk) begin
        if (sample_valid) begin
            pl = ll; pr = lr;
            ll = left_out; lr = right_out;
            vcount = vcount + 1;
            if (prev_v) wide_cnt = wide_cnt + 1;
        end
        prev_v = sample_valid;
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] sx(input logic [23:0] w, input int n);
        logic [23:0] mask;
        mask = (24'h1 << n) - 24'h1;
        return w[n-1] ? ((w & mask) | ~mask) : (w & mask);
    endfunction

    // jus: 0 right-justified, 1 left-justified, 2 I2S; unused slots are 1.
    function automatic logic bit_of(input int k, input int h, input int jus,
                                    input int n, input logic [23:0] w);
        if (jus == 0 && k >= h - n) return w[n-1-(k-(h-n))];
        if (jus == 1 && k < n)      return w[n-1-k];
        if (jus == 2 && k >= 1 && k <= n) return w[n-k];
        return 1'b1;
    endfunction

    task automatic send_bit(input logic l, input logic d);
        @(negedge bclk);
        lrck = l;
        sdata = d;
    endtask

    task automatic send_frame(input logic lvl, input int h, input int jus, input int n,
                              input logic [23:0] lw, input logic [23:0] rw);
        for (int k = 0; k < h; k++) send_bit(lvl, bit_of(k, h, jus, n, lw));
        for (int k = 0; k < h; k++) send_bit(~lvl, bit_of(k, h, jus, n, rw));
    endtask

    // Reset, send a sacrificial frame, two checked frames and a closing half phase.
    task automatic run_case(input string req, input logic [2:0] f, input logic swp,
                            input int ratio, input int jus, input int n, input bit expect_out,
                            input logic [23:0] l2, input logic [23:0] r2,
                            input logic [23:0] l3, input logic [23:0] r3);
        int h;
        int base;
        logic lvl;
        h = ratio / 2;
        lvl = (f[2] ? 1'b0 : 1'b1) ^ swp;
        @(negedge bclk);
        rst_n = 1'b0; fmt = f; lr_swap = swp; lrck = lvl; sdata = 1'b0;
        repeat (3) @(negedge bclk);
        base = vcount;
        rst_n = 1'b1;
        send_frame(lvl, h, jus, n, 24'h5A5A5A, 24'hA5A5A5);
        send_frame(lvl, h, jus, n, l2, r2);
        send_frame(lvl, h, jus, n, l3, r3);
        for (int k = 0; k < h; k++) send_bit(lvl, 1'b1);
        repeat (4) @(negedge bclk);
        if (expect_out) begin
            check({req, " R11 R9"}, "pulse count", vcount - base, 2);
            check({req, " R8"}, "left word 2", pl, sx(l2, n));
            check({req, " R8"}, "right word 2", pr, sx(r2, n));
            check({req, " R8"}, "left word 3", ll, sx(l3, n));
            check({req, " R8 R9"}, "right word 3 held", right_out, sx(r3, n));
        end else begin
            check({req, " R10"}, "pulse count", vcount - base, 0);
            check({req, " R10"}, "left unchanged", left_out, 0);
            check({req, " R10"}, "right unchanged", right_out, 0);
        end
    endtask

    task automatic test_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge bclk);
        check("R1", "valid in reset", sample_valid, 0);
        check("R1", "left in reset", left_out, 0);
        check("R1", "right in reset", right_out, 0);
    endtask

    initial begin
        test_reset();
        run_case("R3 R6 R2 rj16x64",  3'b000, 1'b0, 64, 0, 16, 1, 24'h008001, 24'h001234, 24'h007FFF, 24'h00FFFF);
        run_case("R3 R2 rj20x48",     3'b001, 1'b0, 48, 0, 20, 1, 24'h080000, 24'h02468A, 24'h0FFFFE, 24'h012345);
        run_case("R3 rj24x64",        3'b010, 1'b0, 64, 0, 24, 1, 24'h800001, 24'h123456, 24'h7FFFFF, 24'hABCDEF);
        run_case("R3 R2 rj16x32",     3'b000, 1'b0, 32, 0, 16, 1, 24'h00C0DE, 24'h000001, 24'h004321, 24'h00F00F);
        run_case("R3 R7 rj24swap",    3'b010, 1'b1, 64, 0, 24, 1, 24'hFEDCBA, 24'h010203, 24'h400000, 24'hC00001);
        run_case("R4 R6 lj24x64",     3'b011, 1'b0, 64, 1, 24, 1, 24'h876543, 24'h0F0F0F, 24'h000001, 24'hFFFFFF);
        run_case("R4 R7 lj24x48swap", 3'b011, 1'b1, 48, 1, 24, 1, 24'h135790, 24'hE00000, 24'h7F00FF, 24'h800000);
        run_case("R5 R6 i2s16x48",    3'b100, 1'b0, 48, 2, 16, 1, 24'h00ABCD, 24'h001357, 24'h007001, 24'h008000);
        run_case("R5 R6 i2s24x64",    3'b101, 1'b0, 64, 2, 24, 1, 24'hC3C3C3, 24'h3C3C3C, 24'h000100, 24'hFFFFFE);
        run_case("R5 R7 i2s24swap",   3'b101, 1'b1, 64, 2, 24, 1, 24'h112233, 24'h998877, 24'h800080, 24'h7FFF00);
        run_case("R10 code110",       3'b110, 1'b0, 64, 1, 24, 0, 24'h123456, 24'h654321, 24'h111111, 24'h222222);
        run_case("R10 code111",       3'b111, 1'b0, 64, 2, 24, 0, 24'h123456, 24'h654321, 24'h111111, 24'h222222);
        check("R9", "pulses longer than one cycle", wide_cnt, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge bclk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks + 1, errors + 1);
        $finish;
    end

endmodule